// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Every lookup produces two candidate predictions. One comes from a per-branch path: the fetch PC selects a stored history of that branch's own recent outcomes, and that history selects a saturating counter. The other comes from a shared path: a register of the most recent branch outcomes across the whole program selects a second counter table. A third table of chooser counters, indexed by the same shared history, decides which of the two candidates is the final prediction.

The fetch side presents a PC with a valid strobe. It receives the final prediction and a snapshot of the state behind it: the shared history, the branch's own history, and both candidate predictions. The shared history register advances speculatively with each prediction. When the branch resolves, the execution side returns the PC, the real outcome and the unchanged snapshot. Counters and the branch's own history are trained from that snapshot. If the prediction was wrong, the shared history is rebuilt from the snapshot with the correct outcome.

Top module: `tournament_predictor`

## Requirements
- R1: The per-branch history table is indexed by PC bits [11:2]. On a resolve, the entry selected by `rs_pc` is shifted left by one bit with `rs_taken` entering at bit 0. The updated entry is visible on `pred_lhist` at the next lookup of that index.
- R2: The per-branch counter table is indexed by the 10-bit per-branch history. Its counters are 3 bits wide, and `pred_local` is 1 when the selected counter is 4 or more. On a resolve, the counter at `rs_lhist` counts up when `rs_taken` is 1 and down otherwise, saturating at 0 and 7.
- R3: The shared counter table is indexed by the 12-bit shared history. Its counters are 2 bits wide, and `pred_global` is 1 when the selected counter is 2 or more. On a resolve, the counter at `rs_ghist` moves toward `rs_taken`, saturating at 0 and 3.
- R4: The chooser table is indexed by the current shared history. When its 2-bit counter is 2 or more, `pred_taken` equals `pred_global`; otherwise it equals `pred_local`.
- R5: The chooser counter at `rs_ghist` is changed only when `rs_local` differs from `rs_global`. It counts up when `rs_global` equals `rs_taken` and down otherwise, saturating at 0 and 3.
- R6: When `lk_valid` is 1 and no mispredict resolves in the same cycle, the shared history shifts left by one with `pred_taken` entering at bit 0. With neither a lookup nor a mispredict, it holds its value.
- R7: A mispredict is a resolve with `rs_taken` different from `rs_pred`. It sets the shared history to `{rs_ghist[10:0], rs_taken}`, and this takes priority over a lookup in the same cycle.
- R8: When a lookup and a resolve occur in the same cycle, the lookup sees the tables as they were before that cycle's update. The update is visible from the following cycle.
- R9: After reset, all histories are zero, per-branch counters are 3, shared counters are 1 and chooser counters are 1. Every lookup then predicts not taken, with the final prediction taken from the per-branch component.
- R10: `pred_ghist` always shows the current shared history, and `pred_lhist` shows the per-branch history entry selected by `lk_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe; advances the shared history |
| lk_pc | input | 32 | Fetch PC to predict |
| pred_taken | output | 1 | Final prediction |
| pred_ghist | output | 12 | Snapshot: shared history used for this lookup |
| pred_lhist | output | 10 | Snapshot: per-branch history used for this lookup |
| pred_local | output | 1 | Snapshot: per-branch component prediction |
| pred_global | output | 1 | Snapshot: shared component prediction |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | 32 | PC of the resolving branch |
| rs_taken | input | 1 | Actual outcome |
| rs_ghist | input | 12 | Returned shared history snapshot |
| rs_lhist | input | 10 | Returned per-branch history snapshot |
| rs_local | input | 1 | Returned per-branch component prediction |
| rs_global | input | 1 | Returned shared component prediction |
| rs_pred | input | 1 | Returned final prediction |

## Verification
The assertions assume that the snapshot fields on the resolve port are exactly the values the predictor produced for that branch. In particular, they assume `rs_pred` equals the final prediction and `rs_ghist` is the history seen at that lookup, since history restore and chooser training are checked against those fields. The stimulus keeps this by queueing every lookup's snapshot and returning it unchanged when that branch resolves. Resolves are made in order, often in the same cycle as a new lookup. Outcome patterns include always taken, never taken, alternating, two-in-three taken and random. An aliasing PC is included so that two branches share one per-branch history entry.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
   typedef enum logic {
      SRC_LOCAL  = 1'b0,
      SRC_GLOBAL = 1'b1
   } src_e;

   localparam int PC_ALIGN = 2;
endpackage

// File: rtl/tp_ctr_table.sv
`timescale 1ns/1ps
module tp_ctr_table #(
   parameter int IDX_W = 10,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'((1 << (CNT_W - 1)) - 1);

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("tp_ctr_table: IDX_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("tp_ctr_table: CNT_W out of range");
   end

   logic [CNT_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] nxt;

   assign rd_cnt = mem[rd_idx];
   assign cur    = mem[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_up && cur != CNT_MAX)
         nxt = cur + 1'b1;
      else if (!wr_up && cur != '0)
         nxt = cur - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= CNT_INIT;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/tp_hist_table.sv
`timescale 1ns/1ps
module tp_hist_table #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("tp_hist_table: IDX_W out of range");
   end

   logic [HIST_W-1:0] mem [DEPTH];
   logic [HIST_W-1:0] shifted;

   assign rd_hist = mem[rd_idx];

   if (HIST_W == 1) begin : g_one
      assign shifted = wr_bit;
   end else begin : g_many
      assign shifted = {mem[wr_idx][HIST_W-2:0], wr_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= shifted;
      end
   end
endmodule

// File: rtl/tp_ghr.sv
`timescale 1ns/1ps
module tp_ghr #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spec_en,
   input  logic         spec_bit,
   input  logic         fix_en,
   input  logic [W-1:0] fix_base,
   input  logic         fix_bit,
   output logic [W-1:0] hist
);
   if (W < 2) begin : g_bad_w
      $error("tp_ghr: W must be at least 2");
   end

   logic [W-1:0] hist_q;
   assign hist = hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hist_q <= '0;
      else if (fix_en)
         hist_q <= {fix_base[W-2:0], fix_bit};
      else if (spec_en)
         hist_q <= {hist_q[W-2:0], spec_bit};
   end
endmodule

// File: rtl/tournament_predictor.sv
`timescale 1ns/1ps
module tournament_predictor #(
   parameter int PC_W    = 32,
   parameter int LIDX_W  = 10,
   parameter int LHIST_W = 10,
   parameter int LCNT_W  = 3,
   parameter int GHIST_W = 12,
   parameter int GCNT_W  = 2,
   parameter int CCNT_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               pred_taken,
   output logic [GHIST_W-1:0] pred_ghist,
   output logic [LHIST_W-1:0] pred_lhist,
   output logic               pred_local,
   output logic               pred_global,
   input  logic               rs_valid,
   input  logic [PC_W-1:0]    rs_pc,
   input  logic               rs_taken,
   input  logic [GHIST_W-1:0] rs_ghist,
   input  logic [LHIST_W-1:0] rs_lhist,
   input  logic               rs_local,
   input  logic               rs_global,
   input  logic               rs_pred
);
   import tp_pkg::*;

   localparam int IDX_LSB = PC_ALIGN;

   if (PC_W < IDX_LSB + LIDX_W) begin : g_bad_pc
      $error("tournament_predictor: PC too narrow for the history index");
   end

   logic [LIDX_W-1:0]  lk_idx;
   logic [LIDX_W-1:0]  rs_idx;
   logic [GHIST_W-1:0] ghist;
   logic [LHIST_W-1:0] lhist;
   logic [LCNT_W-1:0]  lcnt;
   logic [GCNT_W-1:0]  gcnt;
   logic [CCNT_W-1:0]  ccnt;
   src_e               src;
   logic               mispredict;
   logic               disagree;

   assign lk_idx     = lk_pc[IDX_LSB +: LIDX_W];
   assign rs_idx     = rs_pc[IDX_LSB +: LIDX_W];
   assign mispredict = rs_valid && (rs_taken != rs_pred);
   assign disagree   = rs_valid && (rs_local != rs_global);

   tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_idx),
      .rd_hist (lhist),
      .wr_en   (rs_valid),
      .wr_idx  (rs_idx),
      .wr_bit  (rs_taken)
   );

   tp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_lctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lhist),
      .rd_cnt (lcnt),
      .wr_en  (rs_valid),
      .wr_idx (rs_lhist),
      .wr_up  (rs_taken)
   );

   tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (ghist),
      .rd_cnt (gcnt),
      .wr_en  (rs_valid),
      .wr_idx (rs_ghist),
      .wr_up  (rs_taken)
   );

   tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(CCNT_W)) u_chooser (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (ghist),
      .rd_cnt (ccnt),
      .wr_en  (disagree),
      .wr_idx (rs_ghist),
      .wr_up  (rs_global == rs_taken)
   );

   tp_ghr #(.W(GHIST_W)) u_ghr (
      .clk      (clk),
      .rst_n    (rst_n),
      .spec_en  (lk_valid),
      .spec_bit (pred_taken),
      .fix_en   (mispredict),
      .fix_base (rs_ghist),
      .fix_bit  (rs_taken),
      .hist     (ghist)
   );

   assign src         = ccnt[CCNT_W-1] ? SRC_GLOBAL : SRC_LOCAL;
   assign pred_local  = lcnt[LCNT_W-1];
   assign pred_global = gcnt[GCNT_W-1];
   assign pred_taken  = (src == SRC_GLOBAL) ? pred_global : pred_local;
   assign pred_ghist  = ghist;
   assign pred_lhist  = lhist;
endmodule

// File: rtl/tp_checker.sv
`timescale 1ns/1ps
module tp_checker #(
   parameter int GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               pred_taken,
   input logic [GHIST_W-1:0] pred_ghist,
   input logic               pred_local,
   input logic               pred_global,
   input logic               rs_valid,
   input logic               rs_taken,
   input logic               rs_pred,
   input logic [GHIST_W-1:0] rs_ghist
);
   logic miss;
   assign miss = rs_valid && (rs_taken != rs_pred);

   AST_GHR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> pred_ghist == {$past(rs_ghist[GHIST_W-2:0]), $past(rs_taken)}); // R7

   AST_GHR_SPECULATE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !miss) |=> pred_ghist == {$past(pred_ghist[GHIST_W-2:0]), $past(pred_taken)}); // R6

   AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !miss) |=> $stable(pred_ghist)); // R6

   AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_local == pred_global) |-> (pred_taken == pred_local)); // R4
endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) u_tp_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .pred_taken  (pred_taken),
   .pred_ghist  (pred_ghist),
   .pred_local  (pred_local),
   .pred_global (pred_global),
   .rs_valid    (rs_valid),
   .rs_taken    (rs_taken),
   .rs_pred     (rs_pred),
   .rs_ghist    (rs_ghist)
);

// File: tb/tournament_predictor_test.sv
`timescale 1ns/1ps
module tournament_predictor_test;
   localparam int CLK_PERIOD = 10;
   localparam int LSIZE = 1024;
   localparam int GSIZE = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        pred_taken, pred_local, pred_global;
   logic [11:0] pred_ghist;
   logic [9:0]  pred_lhist;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;
   logic [11:0] rs_ghist = '0;
   logic [9:0]  rs_lhist = '0;
   logic        rs_local = 1'b0, rs_global = 1'b0, rs_pred = 1'b0;

   tournament_predictor uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          sel;
      logic [31:0] pc;
      int          gh;
      int          lh;
      bit          lp, gp, fp;
   } snap_t;

   int    lht [LSIZE];
   int    lct [LSIZE];
   int    gct [GSIZE];
   int    cht [GSIZE];
   int    ghist;
   int    seen [8];
   snap_t q [$];
   int    checks = 0;
   int    fails  = 0;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat(int v, bit up, int mx);
      if (up) return (v < mx) ? v + 1 : v;
      return (v > 0) ? v - 1 : v;
   endfunction

   function automatic logic [31:0] pc_of(int sel);
      // sel 7 aliases sel 0 in PC bits [11:2]
      if (sel == 7) return 32'h0000_2100;
      return 32'h0000_1100 + 32'(sel * 4);
   endfunction

   function automatic bit outcome(int sel, int n);
      case (sel)
         0: return 1'b1;
         1: return n[0];
         2: return (n % 3) != 0;
         3: return 1'b0;
         default: return 1'($urandom % 2);
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < LSIZE; i++) begin lht[i] = 0; lct[i] = 3; end
      for (int i = 0; i < GSIZE; i++) begin gct[i] = 1; cht[i] = 1; end
      for (int i = 0; i < 8; i++) seen[i] = 0;
      ghist = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R9: reset state seen at the ports
      @(negedge clk);
      lk_pc = pc_of(2);
      #1;
      check("R9 pred_taken", int'(pred_taken), 0);
      check("R9 pred_local", int'(pred_local), 0);
      check("R9 pred_global", int'(pred_global), 0);
      check("R9 pred_ghist", int'(pred_ghist), 0);
      check("R9 pred_lhist", int'(pred_lhist), 0);

      for (int cyc = 0; cyc < 4000; cyc++) begin
         int    sel, idx, e_lh, e_gh;
         bit    e_lp, e_gp, e_fp, lv, rv, t;
         snap_t r, s;
         @(negedge clk);
         lv   = ($urandom % 4) != 0;
         sel  = $urandom % 8;
         idx  = int'(pc_of(sel) >> 2) % LSIZE;
         e_gh = ghist;
         e_lh = lht[idx];
         e_lp = lct[e_lh] >= 4;
         e_gp = gct[e_gh] >= 2;
         e_fp = (cht[e_gh] >= 2) ? e_gp : e_lp;
         rv = (q.size() > 0) && ((($urandom % 3) != 0) || q.size() > 6);
         t  = 1'b0;
         if (rv) begin
            r = q.pop_front();
            t = outcome(r.sel, seen[r.sel]);
            seen[r.sel]++;
            rs_pc = r.pc; rs_taken = t; rs_ghist = 12'(r.gh); rs_lhist = 10'(r.lh);
            rs_local = r.lp; rs_global = r.gp; rs_pred = r.fp;
         end
         rs_valid = rv;
         lk_valid = lv;
         lk_pc    = pc_of(sel);
         #1;
         // lookup reads tables before this cycle's resolve (R8)
         check("R1/R10 pred_lhist", int'(pred_lhist), e_lh);
         check("R2 pred_local", int'(pred_local), int'(e_lp));
         check("R3 pred_global", int'(pred_global), int'(e_gp));
         check("R4/R5/R8 pred_taken", int'(pred_taken), int'(e_fp));
         check("R6/R7/R10 pred_ghist", int'(pred_ghist), e_gh);
         if (lv) begin
            s.sel = sel; s.pc = pc_of(sel); s.gh = e_gh; s.lh = e_lh;
            s.lp = e_lp; s.gp = e_gp; s.fp = e_fp;
            q.push_back(s);
         end
         @(posedge clk);
         if (rv) begin
            lct[r.lh] = sat(lct[r.lh], t, 7);
            gct[r.gh] = sat(gct[r.gh], t, 3);
            if (r.lp != r.gp) cht[r.gh] = sat(cht[r.gh], r.gp == t, 3);
            idx = int'(r.pc >> 2) % LSIZE;
            lht[idx] = ((lht[idx] << 1) | int'(t)) % LSIZE;
         end
         if (rv && t != r.fp) ghist = ((r.gh << 1) | int'(t)) % GSIZE;
         else if (lv) ghist = ((ghist << 1) | int'(e_fp)) % GSIZE;
      end

      @(negedge clk);
      lk_valid = 1'b0;
      rs_valid = 1'b0;
      #1;
      check("R6 final pred_ghist", int'(pred_ghist), ghist);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule